// File: doc/BRIEF.md
# Exclusive Two-Level Victim-Swapping Cache Controller

This block tracks tags and line state for a two-level cache hierarchy in which the two levels never share a block. The first level is searched first. The second level holds only lines that the first level has pushed out. A block fetched from memory is placed in the first level alone. Because nothing is stored twice, the number of distinct blocks the hierarchy can hold is the sum of both levels.

A requester presents one block address and a read/write flag while the controller is idle. The controller reports `busy` until the request completes. It then pulses `resp_valid` with an outcome code.

- **First-level hit:** the line is refreshed in place.
- **Second-level hit:** the controller runs a swap. The block is removed from the second level, the least recently used first-level line is pushed down into the freed capacity, and the requested block is installed above. This costs more cycles than a first-level hit.
- **Memory fill:** a miss in both levels follows the same push-down and install steps, without the removal step.

A line's dirty flag moves with the line between levels. When a push-down forces a dirty line out of the second level, that line's address is reported on a writeback output.

Top module: `excl_victim_cache`

## Requirements
- R1: A block address is never valid in both levels at the same time. A block that is pushed down from the first level is therefore reported as a second-level hit (code 01) on its next access, not as a first-level hit.
- R2: A request that hits in the first level returns outcome code 00 after exactly one busy cycle, and it marks that line most recently used.
- R3: A request that misses the first level and hits the second level returns code 01. The block then sits in the first level only, and its second-level entry is free.
- R4: The first-level line displaced by a fill or a swap is written into the second level of its own set. An access to that line afterwards returns code 01.
- R5: A request that misses both levels returns code 10. The fetched block is installed in the first level only, and an immediate repeat access returns code 00.
- R6: A request is accepted on a clock edge where `busy` is low and `req_valid` is high. `busy` then stays high for 1 cycle (code 00), 3 cycles (code 10) or 4 cycles (code 01). `resp_valid` is a one-cycle pulse in the first cycle with `busy` low.
- R7: The dirty flag of a line is set by a write and carries with the line between levels. When a push into the second level replaces a valid dirty line, `wb_valid` pulses for one cycle, and `wb_addr` gives the replaced block's address. A clean replacement gives no pulse. The pulse comes one cycle before `resp_valid`, on a request with code 01 or 10.
- R8: Each level chooses a victim from the set the address maps to, using the low address bits as the set index. It takes an invalid way first. Otherwise it takes the least recently used way, where recency is updated by first-level hits and by every install.
- R9: When a group of blocks maps to one first-level set and one second-level set, and the group is no larger than the combined associativity, cycling through it after one warm-up pass gives code 01 on every access.
- R10: After reset both levels are empty, and `busy`, `resp_valid` and `wb_valid` are low. The first access to any address returns code 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_addr | input | ADDR_W | Block address of the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| busy | output | 1 | High while a request is in progress |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_code | output | 2 | 00 first-level hit, 01 second-level hit, 10 memory fill |
| wb_valid | output | 1 | One-cycle pulse: a dirty line left the second level |
| wb_addr | output | ADDR_W | Block address of the written-back line |

## Verification
The bench builds the block with its defaults: 12-bit block addresses, a 4-set 2-way first level and an 8-set 4-way second level. At these sizes, six blocks that agree in their low three address bits fill one first-level set and one second-level set together. This brings full-set swaps, LRU victim choice and dirty second-level evictions within reach in a few dozen requests. Random traffic is confined to 48 block addresses, slightly more than the 40-block combined capacity, so all three outcome codes and writebacks occur often. A bench reference model of both levels predicts the code, the busy length and any writeback for every request.

// File: rtl/excl_cache_pkg.sv
// Shared definitions for the exclusive victim-swapping cache controller.
// Assumes: outcome codes are fixed so any requester can decode them.
package excl_cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for a request
        ST_LOOK,     // both levels searched
        ST_XTRACT,   // second-level entry of the requested block freed
        ST_PUSH,     // first-level victim written into the second level
        ST_FILL      // requested block installed in the first level
    } swap_state_t;

    localparam logic [1:0] OUT_L1_HIT = 2'b00;
    localparam logic [1:0] OUT_L2_HIT = 2'b01;
    localparam logic [1:0] OUT_MEMORY = 2'b10;

endpackage

// File: rtl/lru_tag_store.sv
// Set-associative tag/state store with true-LRU ordering by per-way age.
// Lookup is combinational on lk_addr: hit way, plus the victim way of the
// same set (first invalid way, else the oldest way).
// One write per cycle; a write with wr_valid=1 makes that way most recent,
// an invalidating write leaves the ages alone.
// Assumes: SETS and WAYS are powers of two, both at least 2.
module lru_tag_store #(
    parameter int ADDR_W = 12,
    parameter int SETS   = 4,
    parameter int WAYS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [$clog2(WAYS)-1:0] lk_way,
    output logic              lk_dirty,
    output logic [$clog2(WAYS)-1:0] vic_way,
    output logic              vic_valid,
    output logic [ADDR_W-1:0] vic_addr,
    output logic              vic_dirty,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [$clog2(WAYS)-1:0] wr_way,
    input  logic              wr_valid,
    input  logic              wr_dirty
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - SET_W;

    logic             vld   [SETS][WAYS];
    logic             dty   [SETS][WAYS];
    logic [TAG_W-1:0] tag   [SETS][WAYS];
    logic [WAY_W-1:0] age   [SETS][WAYS];

    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic [SET_W-1:0] wr_set;
    logic [TAG_W-1:0] wr_tag;
    logic             free_found;

    assign lk_set = lk_addr[SET_W-1:0];
    assign lk_tag = lk_addr[ADDR_W-1:SET_W];
    assign wr_set = wr_addr[SET_W-1:0];
    assign wr_tag = wr_addr[ADDR_W-1:SET_W];

    // Tag compare across the ways of the looked-up set.
    always_comb begin
        lk_hit   = 1'b0;
        lk_way   = '0;
        lk_dirty = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld[lk_set][w] && tag[lk_set][w] == lk_tag) begin
                lk_hit   = 1'b1;
                lk_way   = WAY_W'(w);
                lk_dirty = dty[lk_set][w];
            end
        end
    end

    // Victim choice: lowest invalid way, otherwise the oldest way.
    always_comb begin
        free_found = 1'b0;
        vic_way    = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!vld[lk_set][w] && !free_found) begin
                free_found = 1'b1;
                vic_way    = WAY_W'(w);
            end
        end
        if (!free_found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age[lk_set][w] == WAY_W'(WAYS - 1)) begin
                    vic_way = WAY_W'(w);
                end
            end
        end
    end

    assign vic_valid = vld[lk_set][vic_way];
    assign vic_dirty = dty[lk_set][vic_way];
    assign vic_addr  = {tag[lk_set][vic_way], lk_set};

    // Entry update and recency ordering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    vld[s][w] <= 1'b0;
                    dty[s][w] <= 1'b0;
                    tag[s][w] <= '0;
                    age[s][w] <= WAY_W'(w);
                end
            end
        end else if (wr_en) begin
            vld[wr_set][wr_way] <= wr_valid;
            dty[wr_set][wr_way] <= wr_dirty;
            tag[wr_set][wr_way] <= wr_tag;
            if (wr_valid) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == wr_way) begin
                        age[wr_set][w] <= '0;
                    end else if (age[wr_set][w] < age[wr_set][wr_way]) begin
                        age[wr_set][w] <= age[wr_set][w] + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/swap_sequencer.sv
// Step sequencer for one request: look up, then either finish (first-level
// hit) or run free-below / push-down / install steps.
// Assumes: a request is only taken in ST_IDLE; the step count is fixed
// per outcome, whether or not a victim actually exists.
module swap_sequencer
    import excl_cache_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        l1_hit,
    input  logic        l2_hit,
    output swap_state_t state
);
    swap_state_t nxt;

    // Next-step selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = ST_LOOK;
            ST_LOOK:   nxt = l1_hit ? ST_IDLE : (l2_hit ? ST_XTRACT : ST_PUSH);
            ST_XTRACT: nxt = ST_PUSH;
            ST_PUSH:   nxt = ST_FILL;
            ST_FILL:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

endmodule

// File: rtl/excl_victim_cache.sv
// Exclusive two-level cache tag controller. The second level only receives
// first-level victims; a second-level hit frees the entry below, pushes the
// first-level victim down and installs the block above.
// Assumes: requester waits for busy low; tags and state only, no data.
module excl_victim_cache
    import excl_cache_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int L1_SETS = 4,
    parameter int L1_WAYS = 2,
    parameter int L2_SETS = 8,
    parameter int L2_WAYS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              busy,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr
);
    localparam int L1_WW = $clog2(L1_WAYS);
    localparam int L2_WW = $clog2(L2_WAYS);

    swap_state_t state;

    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic              blk_dirty_q;
    logic              from_l2_q;

    logic              l1_lk_hit, l1_lk_dirty, l1_vic_valid, l1_vic_dirty;
    logic [L1_WW-1:0]  l1_lk_way, l1_vic_way, l1_wr_way;
    logic [ADDR_W-1:0] l1_vic_addr;
    logic              l1_wr_en, l1_wr_dirty;

    logic              l2_lk_hit, l2_lk_dirty, l2_vic_valid, l2_vic_dirty;
    logic [L2_WW-1:0]  l2_lk_way, l2_vic_way, l2_wr_way;
    logic [ADDR_W-1:0] l2_vic_addr, l2_lk_addr, l2_wr_addr;
    logic              l2_wr_en, l2_wr_valid, l2_wr_dirty;

    logic              in_look, in_xtract, in_push, in_fill;

    assign in_look   = (state == ST_LOOK);
    assign in_xtract = (state == ST_XTRACT);
    assign in_push   = (state == ST_PUSH);
    assign in_fill   = (state == ST_FILL);
    assign busy      = (state != ST_IDLE);

    swap_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .l1_hit    (l1_lk_hit),
        .l2_hit    (l2_lk_hit),
        .state     (state)
    );

    // First level: refreshed on a hit, written with the block on a fill.
    assign l1_wr_en    = (in_look && l1_lk_hit) || in_fill;
    assign l1_wr_way   = in_look ? l1_lk_way : l1_vic_way;
    assign l1_wr_dirty = (in_look ? l1_lk_dirty : blk_dirty_q) | write_q;

    lru_tag_store #(.ADDR_W(ADDR_W), .SETS(L1_SETS), .WAYS(L1_WAYS)) u_l1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_addr   (addr_q),
        .lk_hit    (l1_lk_hit),
        .lk_way    (l1_lk_way),
        .lk_dirty  (l1_lk_dirty),
        .vic_way   (l1_vic_way),
        .vic_valid (l1_vic_valid),
        .vic_addr  (l1_vic_addr),
        .vic_dirty (l1_vic_dirty),
        .wr_en     (l1_wr_en),
        .wr_addr   (addr_q),
        .wr_way    (l1_wr_way),
        .wr_valid  (1'b1),
        .wr_dirty  (l1_wr_dirty)
    );

    // Second level: searched for the request, then for the pushed victim.
    assign l2_lk_addr  = in_push ? l1_vic_addr : addr_q;
    assign l2_wr_en    = in_xtract || (in_push && l1_vic_valid);
    assign l2_wr_way   = in_xtract ? l2_lk_way : l2_vic_way;
    assign l2_wr_addr  = in_xtract ? addr_q : l1_vic_addr;
    assign l2_wr_valid = in_push;
    assign l2_wr_dirty = in_push && l1_vic_dirty;

    lru_tag_store #(.ADDR_W(ADDR_W), .SETS(L2_SETS), .WAYS(L2_WAYS)) u_l2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_addr   (l2_lk_addr),
        .lk_hit    (l2_lk_hit),
        .lk_way    (l2_lk_way),
        .lk_dirty  (l2_lk_dirty),
        .vic_way   (l2_vic_way),
        .vic_valid (l2_vic_valid),
        .vic_addr  (l2_vic_addr),
        .vic_dirty (l2_vic_dirty),
        .wr_en     (l2_wr_en),
        .wr_addr   (l2_wr_addr),
        .wr_way    (l2_wr_way),
        .wr_valid  (l2_wr_valid),
        .wr_dirty  (l2_wr_dirty)
    );

    // Request capture and the dirty flag carried up from the second level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            write_q     <= 1'b0;
            blk_dirty_q <= 1'b0;
            from_l2_q   <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                write_q <= req_write;
            end
            if (in_look) begin
                from_l2_q   <= l2_lk_hit;
                blk_dirty_q <= l2_lk_hit && l2_lk_dirty;
            end
        end
    end

    // Completion pulse and dirty-eviction report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= OUT_L1_HIT;
            wb_valid   <= 1'b0;
            wb_addr    <= '0;
        end else begin
            resp_valid <= (in_look && l1_lk_hit) || in_fill;
            if (in_look && l1_lk_hit) resp_code <= OUT_L1_HIT;
            else if (in_fill)         resp_code <= from_l2_q ? OUT_L2_HIT : OUT_MEMORY;
            wb_valid <= in_push && l1_vic_valid && l2_vic_valid && l2_vic_dirty;
            if (in_push) wb_addr <= l2_vic_addr;
        end
    end

endmodule

// File: rtl/excl_cache_checker.sv
// Protocol and exclusivity properties for excl_victim_cache, bound in.
// Assumes: the bench asserts reset for several cycles before traffic.
module excl_cache_checker
    import excl_cache_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        resp_valid,
    input logic [1:0]  resp_code,
    input logic        wb_valid,
    input logic        l1_hit,
    input logic        l2_hit,
    input swap_state_t state
);
    AST_NO_DUAL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOK) |-> !(l1_hit && l2_hit)); // R1

    AST_FREED_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> !l2_hit); // R3

    AST_L1_HIT_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == OUT_L1_HIT) |-> ($past(busy) && !$past(busy, 2))); // R2

    AST_L2_HIT_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == OUT_L2_HIT) |-> ($past(busy) && $past(busy, 4) && !$past(busy, 5))); // R6

    AST_MEM_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == OUT_MEMORY) |-> ($past(busy) && $past(busy, 3) && !$past(busy, 4))); // R5

    AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !busy); // R6

    AST_WB_LEADS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (resp_valid && resp_code != OUT_L1_HIT)); // R7

endmodule

bind excl_victim_cache excl_cache_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .wb_valid   (wb_valid),
    .l1_hit     (l1_lk_hit),
    .l2_hit     (l2_lk_hit),
    .state      (state)
);

// File: tb/excl_victim_cache_test.sv
// Self-checking bench: reference model of both levels, directed corner
// sequences, then seeded random traffic.
module excl_victim_cache_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 12;
    localparam int S1  = 4;
    localparam int W1  = 2;
    localparam int S2  = 8;
    localparam int W2  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          busy, resp_valid, wb_valid;
    logic [1:0]    resp_code;
    logic [AW-1:0] wb_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    bit m1_v [S1][W1]; int m1_a [S1][W1]; bit m1_d [S1][W1]; int m1_t [S1][W1];
    bit m2_v [S2][W2]; int m2_a [S2][W2]; bit m2_d [S2][W2]; int m2_t [S2][W2];
    int stamp = 0;

    excl_victim_cache #(.ADDR_W(AW), .L1_SETS(S1), .L1_WAYS(W1),
                        .L2_SETS(S2), .L2_WAYS(W2)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .busy(busy), .resp_valid(resp_valid),
        .resp_code(resp_code), .wb_valid(wb_valid), .wb_addr(wb_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pick_slot2(input int s);
        int best = 0;
        for (int w = 0; w < W2; w++) if (!m2_v[s][w]) return w;
        for (int w = 1; w < W2; w++) if (m2_t[s][w] < m2_t[s][best]) best = w;
        return best;
    endfunction

    function automatic int pick_slot1(input int s);
        int best = 0;
        for (int w = 0; w < W1; w++) if (!m1_v[s][w]) return w;
        for (int w = 1; w < W1; w++) if (m1_t[s][w] < m1_t[s][best]) best = w;
        return best;
    endfunction

    // Model one request: outcome code and any dirty writeback.
    task automatic model(input int a, input bit wr, output int code,
                         output bit wb, output int wba);
        int s1 = a % S1;
        int s2 = a % S2;
        bit d = 0;
        wb = 0; wba = 0; code = 2;
        for (int w = 0; w < W1; w++) begin
            if (m1_v[s1][w] && m1_a[s1][w] == a) begin
                code = 0; stamp++; m1_t[s1][w] = stamp; m1_d[s1][w] |= wr;
            end
        end
        if (code == 0) return;
        for (int w = 0; w < W2; w++) begin
            if (m2_v[s2][w] && m2_a[s2][w] == a) begin
                code = 1; d = m2_d[s2][w]; m2_v[s2][w] = 0;
            end
        end
        begin
            int v1 = pick_slot1(s1);
            if (m1_v[s1][v1]) begin
                int va = m1_a[s1][v1];
                int vs = va % S2;
                int v2 = pick_slot2(vs);
                if (m2_v[vs][v2] && m2_d[vs][v2]) begin wb = 1; wba = m2_a[vs][v2]; end
                stamp++;
                m2_v[vs][v2] = 1; m2_a[vs][v2] = va; m2_d[vs][v2] = m1_d[s1][v1];
                m2_t[vs][v2] = stamp;
            end
            stamp++;
            m1_v[s1][v1] = 1; m1_a[s1][v1] = a; m1_d[s1][v1] = d | wr; m1_t[s1][v1] = stamp;
        end
    endtask

    // Drive one request, compare code, busy length and writeback to the model.
    task automatic access(input int a, input bit wr, input string tag, output int got);
        int ecode, ewba, wba, lat, guard, elat;
        bit ewb, gwb;
        model(a, wr, ecode, ewb, ewba);
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(a); req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0; guard = 0; gwb = 0; wba = 0;
        while (!resp_valid && guard < 20) begin
            if (busy) lat++;
            if (wb_valid) begin gwb = 1; wba = int'(wb_addr); end
            @(negedge clk);
            guard++;
        end
        got = int'(resp_code);
        check(resp_valid == 1'b1, "R6", "response pulse", int'(resp_valid), 1);
        check(got == ecode, tag, "outcome code", got, ecode);
        elat = (ecode == 0) ? 1 : ((ecode == 1) ? 4 : 3);
        check(lat == elat, "R6", "busy cycles", lat, elat);
        check(busy == 1'b0, "R6", "busy with response", int'(busy), 0);
        check(gwb == ewb, "R7", "writeback pulse", int'(gwb), int'(ewb));
        if (gwb && ewb) check(wba == ewba, "R7", "writeback address", wba, ewba);
    endtask

    initial begin
        int got;
        repeat (4) @(negedge clk);
        // R10: idle outputs after reset
        check(busy == 1'b0, "R10", "busy after reset", int'(busy), 0);
        check(resp_valid == 1'b0, "R10", "resp after reset", int'(resp_valid), 0);
        check(wb_valid == 1'b0, "R10", "wb after reset", int'(wb_valid), 0);
        rst_n = 1'b1;
        access(0, 0, "R10", got);
        check(got == 2, "R10", "first access fills from memory", got, 2);

        // R9: six blocks sharing one set in each level cycle without memory fills
        for (int k = 0; k < 6; k++) access(k * 8, 0, "R9", got);
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 6; k++) begin
                access(k * 8, 0, "R9", got);
                check(got == 1, "R9", "combined capacity hit", got, 1);
            end
        end

        // R4, R1: pushed-down victim is found below, not above
        access(12'h301, 0, "R5", got);
        access(12'h309, 1, "R5", got);
        access(12'h311, 0, "R5", got);
        access(12'h301, 0, "R4", got);
        check(got == 1, "R4", "victim found in second level", got, 1);
        access(12'h309, 0, "R1", got);
        check(got == 1, "R1", "no duplicate above", got, 1);
        // R3: swapped-up block now answers from the first level
        access(12'h309, 0, "R3", got);
        check(got == 0, "R3", "block moved up", got, 0);

        // R8: recency decides the first-level victim
        access(12'h402, 0, "R5", got);
        access(12'h406, 0, "R5", got);
        access(12'h402, 0, "R2", got);
        access(12'h40A, 0, "R5", got);
        access(12'h402, 0, "R8", got);
        check(got == 0, "R8", "recent line kept", got, 0);
        access(12'h406, 0, "R8", got);
        check(got == 1, "R8", "oldest line pushed down", got, 1);

        // R5: memory fill lands in the first level
        access(12'h503, 1, "R5", got);
        access(12'h503, 0, "R5", got);
        check(got == 0, "R5", "repeat after fill", got, 0);

        // R7: dirty blocks forced out of a full second-level set
        for (int k = 0; k < 8; k++) access(12'h600 + k * 8, 1, "R7", got);

        // Random traffic over a slightly oversubscribed address range
        void'($urandom(32'd2024));
        for (int i = 0; i < 600; i++) begin
            int a = $urandom_range(0, 47);
            bit w = 1'($urandom_range(0, 1));
            access(a, w, "R2", got);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule